// File: doc/BRIEF.md
# Exclusive access reservation monitor

This block sits next to one core and backs load-linked / store-conditional sequences. A load-exclusive records the aligned granule that holds its address. The reservation then survives only while no other agent writes into that granule and no interrupt or context-switch event arrives. When the core later issues a store-exclusive, the monitor decides in the same cycle whether the store may reach memory. It drives the memory write enable and a status word to match that decision.

Tracking is deliberately coarse. There is one granule per core, compared only above the granule offset bits. Events clear the reservation without looking at any address. Software must therefore retry a failed store-exclusive, and it must tolerate failures that happen even though the exact location never changed. Plain stores from the core pass straight through to the write enable. Clear-exclusive drops the reservation and stores nothing.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is invalid, so a store-exclusive issued before any load-exclusive fails and does not write.
- R2: A load-exclusive followed by a store-exclusive to the same address, with no intervening snoop, event, clear or other store-exclusive, succeeds. In the cycle the store-exclusive request is presented, `mem_we_o` is 1 and the status is 0.
- R3: The status word is 0 for success and 1 for failure, zero-extended to STATUS_W bits. `sc_done_o` is high exactly in cycles that carry a valid store-exclusive (op code 2), and the status is 0 in every other cycle. A failing store-exclusive never raises `mem_we_o`.
- R4: A valid snooped write whose address lies anywhere in the reserved granule (same address bits above bit GRAN_LG-1) breaks the reservation. A snooped write outside the granule leaves it intact. This holds on every snoop port.
- R5: A store-exclusive to a different byte inside the reserved granule succeeds. A store-exclusive to an address outside the reserved granule fails and does not write.
- R6: A new load-exclusive (op code 1) replaces any earlier reservation, even if a snoop or event arrives in the same cycle.
- R7: A clear-exclusive (op code 3) drops the reservation and does not raise `mem_we_o`.
- R8: An interrupt/context-switch event clears the reservation. A store-exclusive in the same cycle as an event fails.
- R9: Every store-exclusive clears the reservation, whether it succeeds or fails, so a second store-exclusive without a new load-exclusive fails.
- R10: A snooped write to the reserved granule in the same cycle as a store-exclusive is ordered first, so the store-exclusive fails.
- R11: A valid plain store (op code 0) always raises `mem_we_o` and leaves the reservation unchanged. No write enable is raised when `req_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request valid |
| req_op_i | input | 2 | 0 store, 1 load-exclusive, 2 store-exclusive, 3 clear-exclusive |
| req_addr_i | input | ADDR_W | Request byte address |
| snp_valid_i | input | SNP_PORTS | Per-port valid of other agents' writes |
| snp_addr_i | input | SNP_PORTS*ADDR_W | Packed snooped write addresses, port k at bits k*ADDR_W upward |
| evt_i | input | 1 | Interrupt or context-switch event |
| mem_we_o | output | 1 | Memory write enable for the current request |
| sc_done_o | output | 1 | Store-exclusive result valid this cycle |
| sc_status_o | output | STATUS_W | 0 success, 1 failure |

## Verification
The bench builds the monitor with a 16-bit address, 64-byte granules and three snoop ports. Random addresses are drawn from only four granules, so snoop hits, offset-only differences and granule misses all occur often. The third snoop port shows that the match covers every port and not just the first. A 32-bit status word checks the zero extension of the result.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_LDEX  = 2'd1,
    OP_STEX  = 2'd2,
    OP_CLREX = 2'd3
  } excl_op_e;
endpackage

// File: rtl/excl_gran_match.sv
module excl_gran_match #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LG   = 6,
  parameter int SNP_PORTS = 2
) (
  input  logic [ADDR_W-1:0]           resv_base_i,
  input  logic [SNP_PORTS-1:0]        snp_valid_i,
  input  logic [SNP_PORTS*ADDR_W-1:0] snp_addr_i,
  output logic                        hit_o
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LG) - ADDR_W'(1));

  logic [SNP_PORTS-1:0] port_hit;

  for (genvar k = 0; k < SNP_PORTS; k++) begin : g_port
    assign port_hit[k] = snp_valid_i[k] &&
                         ((snp_addr_i[k*ADDR_W +: ADDR_W] & GRAN_MASK) == resv_base_i);
  end

  assign hit_o = |port_hit;
endmodule

// File: rtl/excl_resv_reg.sv
module excl_resv_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_base_i,
  input  logic              kill_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      base_o <= '0;
    end else if (set_i) begin
      vld_o  <= 1'b1;
      base_o <= set_base_i;
    end else if (kill_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LG   = 6,
  parameter int SNP_PORTS = 2,
  parameter int STATUS_W  = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [1:0]                  req_op_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [SNP_PORTS-1:0]        snp_valid_i,
  input  logic [SNP_PORTS*ADDR_W-1:0] snp_addr_i,
  input  logic                        evt_i,
  output logic                        mem_we_o,
  output logic                        sc_done_o,
  output logic [STATUS_W-1:0]         sc_status_o
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LG) - ADDR_W'(1));

  excl_op_e          op;
  logic              is_st, is_ld, is_sc, is_clr;
  logic [ADDR_W-1:0] req_base, resv_base;
  logic              resv_vld, snp_hit, sc_ok, kill;

  assign op     = excl_op_e'(req_op_i);
  assign is_st  = req_valid_i && (op == OP_STORE);
  assign is_ld  = req_valid_i && (op == OP_LDEX);
  assign is_sc  = req_valid_i && (op == OP_STEX);
  assign is_clr = req_valid_i && (op == OP_CLREX);

  assign req_base = req_addr_i & GRAN_MASK;

  excl_gran_match #(
    .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .SNP_PORTS(SNP_PORTS)
  ) u_match (
    .resv_base_i (resv_base),
    .snp_valid_i (snp_valid_i),
    .snp_addr_i  (snp_addr_i),
    .hit_o       (snp_hit)
  );

  // snoops and events are ordered ahead of the store-exclusive
  assign sc_ok = is_sc && resv_vld && (req_base == resv_base) && !snp_hit && !evt_i;
  assign kill  = is_sc || is_clr || evt_i || (resv_vld && snp_hit);

  excl_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (is_ld),
    .set_base_i (req_base),
    .kill_i     (kill),
    .vld_o      (resv_vld),
    .base_o     (resv_base)
  );

  assign mem_we_o    = is_st || sc_ok;
  assign sc_done_o   = is_sc;
  assign sc_status_o = {{(STATUS_W-1){1'b0}}, is_sc && !sc_ok};
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int STATUS_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [1:0]          req_op_i,
  input logic                evt_i,
  input logic                mem_we_o,
  input logic                sc_done_o,
  input logic [STATUS_W-1:0] sc_status_o,
  input logic                resv_vld_i
);
  p_ld_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd1) |=> resv_vld_i);

  p_clr_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd3) |=> !resv_vld_i);

  p_evt_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !(req_valid_i && req_op_i == 2'd1)) |=> !resv_vld_i);

  p_sc_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd2) |=> !resv_vld_i);

  p_fail_nowr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_done_o && sc_status_o != '0) |-> !mem_we_o);

  p_ok_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_done_o && sc_status_o == '0) |-> mem_we_o);

  p_store_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd0) |-> mem_we_o);

  p_idle_nowr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_we_o && !sc_done_o));
endmodule

bind excl_monitor excl_monitor_chk #(.STATUS_W(STATUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .evt_i       (evt_i),
  .mem_we_o    (mem_we_o),
  .sc_done_o   (sc_done_o),
  .sc_status_o (sc_status_o),
  .resv_vld_i  (resv_vld)
);

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
  localparam int AW = 16;
  localparam int GL = 6;
  localparam int NP = 3;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [NP-1:0] snp_valid = '0;
  logic [NP*AW-1:0] snp_addr = '0;
  logic          evt = 1'b0;
  logic          mem_we, sc_done;
  logic [SW-1:0] sc_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bit            m_vld = 0;
  logic [AW-1:0] m_base = '0;

  always #2.5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRAN_LG(GL), .SNP_PORTS(NP), .STATUS_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .snp_valid_i(snp_valid), .snp_addr_i(snp_addr),
    .evt_i(evt), .mem_we_o(mem_we), .sc_done_o(sc_done), .sc_status_o(sc_status)
  );

  function automatic logic [AW-1:0] gbase(input logic [AW-1:0] a);
    return a & ~AW'((1 << GL) - 1);
  endfunction

  function automatic bit snoop_hit(input logic [NP-1:0] sv, input logic [NP*AW-1:0] sa);
    bit h = 0;
    for (int k = 0; k < NP; k++)
      if (sv[k] && m_vld && gbase(sa[k*AW +: AW]) == m_base) h = 1;
    return h;
  endfunction

  task automatic step(input bit rv, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [NP-1:0] sv, input logic [NP*AW-1:0] sa,
                      input bit ev, input string tag);
    bit hit, ok, e_we, e_done;
    logic [SW-1:0] e_st;
    @(negedge clk);
    req_valid = rv; req_op = op; req_addr = a;
    snp_valid = sv; snp_addr = sa; evt = ev;
    #1;
    hit    = snoop_hit(sv, sa);
    e_done = rv && op == 2'd2;
    ok     = e_done && m_vld && gbase(a) == m_base && !hit && !ev;
    e_we   = (rv && op == 2'd0) || ok;
    e_st   = (e_done && !ok) ? SW'(1) : '0;
    n_chk++;
    if (mem_we !== e_we || sc_done !== e_done || sc_status !== e_st) begin
      n_bad++;
      $display("FAIL %s: we/done/status got %0b/%0b/%0h exp %0b/%0b/%0h",
               tag, mem_we, sc_done, sc_status, e_we, e_done, e_st);
    end
    if (rv && op == 2'd1) begin
      m_vld = 1; m_base = gbase(a);
    end else if ((rv && (op == 2'd2 || op == 2'd3)) || ev || hit) begin
      m_vld = 0;
    end
  endtask

  task automatic req(input logic [1:0] op, input logic [AW-1:0] a, input string tag);
    step(1'b1, op, a, '0, '0, 1'b0, tag);
  endtask

  function automatic logic [NP*AW-1:0] on_port(input int k, input logic [AW-1:0] a);
    logic [NP*AW-1:0] v = '0;
    v[k*AW +: AW] = a;
    return v;
  endfunction

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: no reservation after reset
    req(2'd2, 16'h0100, "R1");
    // R2, R3: basic success and status
    req(2'd1, 16'h0100, "R2"); req(2'd2, 16'h0100, "R2_R3");
    // R5: coarse granule
    req(2'd1, 16'h0100, "R5"); req(2'd2, 16'h013F, "R5_in");
    req(2'd1, 16'h0100, "R5"); req(2'd2, 16'h0140, "R5_out");
    // R4: snoop in / out of granule, last port
    req(2'd1, 16'h0200, "R4");
    step(1'b0, 2'd0, '0, 3'b100, on_port(2, 16'h023C), 1'b0, "R4_hit");
    req(2'd2, 16'h0200, "R4");
    req(2'd1, 16'h0200, "R4");
    step(1'b0, 2'd0, '0, 3'b010, on_port(1, 16'h0240), 1'b0, "R4_miss");
    req(2'd2, 16'h0200, "R4");
    // R6: replacement
    req(2'd1, 16'h0100, "R6"); req(2'd1, 16'h0300, "R6"); req(2'd2, 16'h0100, "R6_old");
    req(2'd1, 16'h0100, "R6"); req(2'd1, 16'h0300, "R6"); req(2'd2, 16'h0300, "R6_new");
    step(1'b1, 2'd1, 16'h0300, 3'b001, on_port(0, 16'h0300), 1'b1, "R6_same_cycle");
    req(2'd2, 16'h0300, "R6");
    // R7: clear-exclusive
    req(2'd1, 16'h0100, "R7"); req(2'd3, 16'h0100, "R7_clr"); req(2'd2, 16'h0100, "R7");
    // R8: events
    req(2'd1, 16'h0100, "R8");
    step(1'b0, 2'd0, '0, '0, '0, 1'b1, "R8_evt");
    req(2'd2, 16'h0100, "R8");
    req(2'd1, 16'h0100, "R8");
    step(1'b1, 2'd2, 16'h0100, '0, '0, 1'b1, "R8_same_cycle");
    // R9: every store-exclusive clears
    req(2'd1, 16'h0100, "R9"); req(2'd2, 16'h0100, "R9"); req(2'd2, 16'h0100, "R9_second");
    // R10: snoop ordered before store-exclusive
    req(2'd1, 16'h0100, "R10");
    step(1'b1, 2'd2, 16'h0100, 3'b010, on_port(1, 16'h0110), 1'b0, "R10");
    // R11: plain stores
    req(2'd1, 16'h0100, "R11"); req(2'd0, 16'h0100, "R11_st"); req(2'd2, 16'h0100, "R11");
    step(1'b0, 2'd0, 16'h0100, '0, '0, 1'b0, "R11_idle");
    step(1'b0, 2'd2, 16'h0100, '0, '0, 1'b0, "R3_idle");
    // random mix over four granules
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0] sv;
      logic [NP*AW-1:0] sa;
      for (int k = 0; k < NP; k++) begin
        sv[k] = ($urandom_range(0, 5) == 0);
        sa[k*AW +: AW] = AW'(($urandom_range(0, 3) << GL) | $urandom_range(0, 63));
      end
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
           AW'(($urandom_range(0, 3) << GL) | $urandom_range(0, 63)),
           sv, sa, $urandom_range(0, 15) == 0, "rand_R2_R10");
    end
    finish_run();
  end
endmodule